// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is a register-mapped 8-bit general-purpose I/O port. Each pin owns one bit of a data register and one bit of a configuration register. The pin's mode comes from the pair of bits. With configuration clear, the pin is an input, and its data bit switches a weak pull-up on or off. With configuration set, the pin drives a push-pull level equal to its data bit. A third, read-only register returns the pin levels after a two-flop synchroniser.

Two pins are fixed as inputs. Configuration writes to them are dropped, and their configuration bits read back as zero. Writing a one into the top data bit makes the block raise a one-cycle halt request toward the clock controller. Each pin also has an alternate-function enable. When it is set, an external alternate output value replaces the data bit as the level driven on that pin.

Top module: `gpio_port`

## Requirements
- R1: After reset the data and configuration registers read as zero, and pinOe and pinPullEn are all zero, so every pin is a high-impedance input.
- R2: A pin with configuration 0 and data 0 has pinOe 0 and pinPullEn 0.
- R3: A pin with configuration 0 and data 1 has pinOe 0 and pinPullEn 1.
- R4: A pin with configuration 1 has pinOe 1 and pinPullEn 0. Its pinOut equals its data bit when its altEn bit is 0.
- R5: Pins 6 and 7 (mask 8'hC0) are input-only. A one written to their configuration bits is ignored, they read back 0, and their pinOe stays 0.
- R6: A write to address 0 with bit 7 set raises haltReq for the one cycle that follows the capturing clock edge. Any other write, and any idle cycle, leaves haltReq low.
- R7: Address 2 returns pinIn as it was two rising clock edges earlier. Writes to addresses 2 and 3 change no register.
- R8: When a pin's altEn bit is 1, its pinOut equals the matching altOut bit instead of its data bit.
- R9: Address 0 is data, address 1 is configuration, address 2 is pin state, and address 3 reads as zero. regRdData follows regAddr combinationally. A write takes effect at the rising edge on which regWrEn is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data |
| pinIn | input | 8 | Raw pin levels |
| altEn | input | 8 | Per-pin alternate output enable |
| altOut | input | 8 | Alternate output values |
| pinOe | output | 8 | Per-pin output enable |
| pinOut | output | 8 | Per-pin output value |
| pinPullEn | output | 8 | Per-pin weak pull-up enable |
| haltReq | output | 1 | One-cycle halt request |

## Verification
A single data write with bit 7 set does two things in the same clock edge: it changes the pin mode outputs (pull-up or drive level) and it fires the halt pulse. The random loop writes to address 0 often with bit 7 set. It also places such writes back to back and right after configuration writes. At the following negative edge, the bench compares pinPullEn, pinOut, the data readback and haltReq against its own register model. The pin-state readback is judged in the same cycles, so a pipeline or halt fault shows up against the two-edge input history.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_PIN  = 2'd2;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrCfg;
    rdSel_e rdSel;
  } portStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int HALT_BIT = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [WIDTH-1:0] regWrData,
  output portStrobe_t      strobe,
  output logic             haltReq
);

  always_comb begin
    strobe.wrData = regWrEn && (regAddr == ADDR_DATA);
    strobe.wrCfg  = regWrEn && (regAddr == ADDR_CFG);
    unique case (regAddr)
      ADDR_DATA: strobe.rdSel = SEL_DATA;
      ADDR_CFG:  strobe.rdSel = SEL_CFG;
      ADDR_PIN:  strobe.rdSel = SEL_PIN;
      default:   strobe.rdSel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) haltReq <= 1'b0;
    else       haltReq <= strobe.wrData && regWrData[HALT_BIT];
  end

  // R6: a halt-bit write must produce the pulse on the next cycle
  a_r6_halt_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_DATA && regWrData[HALT_BIT]) |=> haltReq);

  // R6: the pulse never appears without such a write
  a_r6_halt_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |-> $past(regWrEn && regAddr == ADDR_DATA && regWrData[HALT_BIT]));

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH           = 8,
  parameter int               SYNC_STAGES     = 2,
  parameter logic [WIDTH-1:0] INPUT_ONLY_MASK = 8'hC0
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] regWrData,
  output logic [WIDTH-1:0] regRdData,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] altEn,
  input  logic [WIDTH-1:0] altOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinPullEn
);

  localparam logic [WIDTH-1:0] CFG_WRITABLE = ~INPUT_ONLY_MASK;

  logic [WIDTH-1:0] dataReg;
  logic [WIDTH-1:0] cfgReg;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      cfgReg  <= '0;
    end else begin
      if (strobe.wrData) dataReg <= regWrData;
      if (strobe.wrCfg)  cfgReg  <= regWrData & CFG_WRITABLE;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= pinIn;
        else             syncQ[s] <= syncQ[(s > 0) ? s - 1 : 0];
      end
    end

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
      assign pinOe[p]     = cfgReg[p];
      assign pinPullEn[p] = !cfgReg[p] && dataReg[p];
      assign pinOut[p]    = altEn[p] ? altOut[p] : dataReg[p];
    end
  endgenerate

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DATA: regRdData = dataReg;
      SEL_CFG:  regRdData = cfgReg;
      SEL_PIN:  regRdData = syncQ[SYNC_STAGES-1];
      default:  regRdData = '0;
    endcase
  end

  // R5: input-only pins never drive
  a_r5_input_only_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & INPUT_ONLY_MASK) == '0);

  // R4: a driving pin never also pulls up
  a_r4_pull_off_when_driving: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & pinPullEn) == '0);

  // R9: a configuration write is visible after the capturing edge
  a_r9_cfg_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCfg |=> pinOe == ($past(regWrData) & CFG_WRITABLE));

  // R9: data register holds when no data write happens
  a_r9_data_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrData |=> $stable(dataReg));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH           = 8,
  parameter int               HALT_BIT        = 7,
  parameter int               SYNC_STAGES     = 2,
  parameter logic [WIDTH-1:0] INPUT_ONLY_MASK = 8'hC0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [WIDTH-1:0] regWrData,
  output logic [WIDTH-1:0] regRdData,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] altEn,
  input  logic [WIDTH-1:0] altOut,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinPullEn,
  output logic             haltReq
);

  portStrobe_t strobe;

  gpio_port_ctrl #(.WIDTH(WIDTH), .HALT_BIT(HALT_BIT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strobe    (strobe),
    .haltReq   (haltReq)
  );

  gpio_port_dp #(
    .WIDTH          (WIDTH),
    .SYNC_STAGES    (SYNC_STAGES),
    .INPUT_ONLY_MASK(INPUT_ONLY_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .pinIn     (pinIn),
    .altEn     (altEn),
    .altOut    (altOut),
    .pinOe     (pinOe),
    .pinOut    (pinOut),
    .pinPullEn (pinPullEn)
  );

endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;

  localparam int        CLK_PERIOD = 10;
  localparam logic [7:0] IN_ONLY   = 8'hC0;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [7:0] pinIn = '0;
  logic [7:0] altEn = '0;
  logic [7:0] altOut = '0;
  logic [7:0] pinOe, pinOut, pinPullEn;
  logic       haltReq;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mData = '0, mCfg = '0, mQ1 = '0, mQ2 = '0;
  logic       mHalt = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .altEn(altEn), .altOut(altOut), .pinOe(pinOe), .pinOut(pinOut),
    .pinPullEn(pinPullEn), .haltReq(haltReq)
  );

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0:    return mData;
      2'd1:    return mCfg;
      2'd2:    return mQ2;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Compare every output against the bench model (outputs are stable at negedge).
  task automatic checkAll();
    chk("R2/R3/R5 pinOe", pinOe, mCfg);
    chk("R2/R3 pinPullEn", pinPullEn, ~mCfg & mData);
    chk("R4/R8 pinOut", pinOut, (altEn & altOut) | (~altEn & mData));
    chk("R7/R9 regRdData", regRdData, expRead(regAddr));
    chk("R6 haltReq", {7'd0, haltReq}, {7'd0, mHalt});
  endtask

  // One cycle: drive at negedge, check combinational read, clock, update model, check.
  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                      input logic [7:0] pi, input logic [7:0] ae, input logic [7:0] ao);
    regWrEn = we; regAddr = a; regWrData = d; pinIn = pi; altEn = ae; altOut = ao;
    #1;
    chk("R9 comb read", regRdData, expRead(a));
    @(posedge clk);
    mHalt = we && a == 2'd0 && d[7];
    if (we && a == 2'd0) mData = d;
    if (we && a == 2'd1) mCfg = d & ~IN_ONLY;
    mQ2 = mQ1;
    mQ1 = pi;
    @(negedge clk);
    checkAll();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    checkAll();
    chk("R1 pinOe reset", pinOe, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    regAddr = 2'd0; #1; chk("R1 data reads zero", regRdData, 8'h00);
    regAddr = 2'd1; #1; chk("R1 cfg reads zero", regRdData, 8'h00);

    // R3: pull-ups on low pins, R2 on the rest
    step(1'b1, 2'd0, 8'h0F, 8'h00, 8'h00, 8'h00);
    chk("R3 pull on", pinPullEn, 8'h0F);
    // R5: configuration write to input-only pins ignored
    step(1'b1, 2'd1, 8'hFF, 8'h00, 8'h00, 8'h00);
    chk("R5 cfg readback", uut.regRdData & IN_ONLY, 8'h00);
    chk("R5 pinOe", pinOe, 8'h3F);
    // R4: driving pins follow data
    chk("R4 drive value", pinOut & pinOe, 8'h0F);
    // R8: alternate source replaces data
    step(1'b0, 2'd0, 8'h00, 8'h00, 8'h03, 8'h02);
    chk("R8 alt out", pinOut & 8'h03, 8'h02);
    // R6: halt pulse, then back-to-back, then gone
    step(1'b1, 2'd0, 8'h80, 8'h00, 8'h00, 8'h00);
    chk("R6 halt high", {7'd0, haltReq}, 8'h01);
    step(1'b1, 2'd0, 8'h81, 8'h00, 8'h00, 8'h00);
    step(1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R6 halt low", {7'd0, haltReq}, 8'h00);
    step(1'b1, 2'd1, 8'h80, 8'h00, 8'h00, 8'h00);
    chk("R6 no halt from cfg", {7'd0, haltReq}, 8'h00);
    // R7: two-edge latency and ignored writes to address 2/3
    step(1'b1, 2'd2, 8'hAA, 8'h5A, 8'h00, 8'h00);
    chk("R7 one edge not yet", regRdData, 8'h00);
    step(1'b1, 2'd3, 8'h55, 8'h5A, 8'h00, 8'h00);
    step(1'b0, 2'd2, 8'h00, 8'h5A, 8'h00, 8'h00);
    chk("R7 pin value", regRdData, 8'h5A);
    step(1'b0, 2'd3, 8'h00, 8'h5A, 8'h00, 8'h00);
    chk("R9 addr3 zero", regRdData, 8'h00);

    // Random mix, data writes with bit 7 weighted up (R6 overlapping R2/R3/R4)
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a  = 2'($urandom_range(0, 3));
      logic [7:0] d  = 8'($urandom);
      if ($urandom_range(0, 2) == 0) a = 2'd0;
      if ($urandom_range(0, 1) == 0) d[7] = 1'b1;
      step(1'($urandom), a, d, 8'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule